// File: doc/BRIEF.md
# SDR SDRAM Refresh and Self-Refresh Manager

This block keeps a four-bank single-data-rate SDRAM refreshed and takes it into and out of its low-power self-refresh state. A free-running interval counter adds one unit of refresh debt per refresh slot. While any debt is outstanding the block asks the command sequencer for the command bus. Once the bus is granted, the block closes every open row with a single precharge-all and then pays off the whole debt with back-to-back auto refresh commands. It keeps the bus until the last refresh has had its full row-cycle time.

The sequencer may postpone refreshes while it has other traffic. When the debt reaches its ceiling, the block raises an urgent flag, and the sequencer must then stop opening new rows and grant the bus. A sleep request takes the same grant path. After the banks are closed, the block issues a refresh command in the same cycle as it drops the clock enable, and this puts the memory into self-refresh. When the sleep request is withdrawn, the block raises the clock enable first. It then holds the bus with no-operation commands for a row-cycle time before it hands the bus back.

Top module: `srpm_refresh_manager`

## Requirements
- R1: During and right after reset: cke_o is 1, the command is NOP, and req_o, urgent_o, own_o and a10_o are 0.
- R2: One unit of debt is added every INTERVAL = floor(REF_WINDOW_MS·1000·CLK_MHZ / REF_ROWS) cycles (1953 at 125 MHz). With the default settings, req_o first rises 1953 cycles after reset is released. req_o is high only while the block is idle and either debt is outstanding or sleep_req_i is high.
- R3: Commands appear on {cs_n_o,ras_n_o,cas_n_o,we_n_o}: NOP = 0111, precharge = 0010, refresh = 0001. If a grant is accepted while any bit of bank_open_i is set, a precharge with a10_o = 1 appears in the cycle after the grant. The next command follows exactly TRP_CYC = ceil(TRP_NS·CLK_MHZ/1000) cycles later (3 by default).
- R4: If a grant is accepted while all of bank_open_i is clear, the first command is a refresh in the cycle after the grant, with no precharge.
- R5: After each refresh, only NOPs are issued for TRC_CYC−1 cycles, where TRC_CYC = ceil(TRC_NS·CLK_MHZ/1000) (9 by default). own_o falls exactly TRC_CYC cycles after the last refresh, and no debt is left.
- R6: All accumulated debt is paid off in one bus ownership, with refreshes spaced exactly TRC_CYC cycles apart.
- R7: Debt saturates at MAX_DEBT (8 by default). Interval expiries beyond that are lost, so a later grant yields exactly MAX_DEBT refreshes.
- R8: urgent_o is high exactly when the debt equals MAX_DEBT.
- R9: A granted sleep request takes priority over refresh debt. Self-refresh entry is a refresh command with cke_o low in the same cycle, after a precharge-all if any bank is open. Entry clears the debt.
- R10: While in self-refresh, cke_o stays low, only NOPs are issued, req_o stays low and no debt accumulates.
- R11: When sleep_req_i falls, cke_o rises in the next cycle with a NOP. NOPs are then held for TRC_CYC cycles in total before own_o falls.
- R12: The interval count restarts on exit from self-refresh: req_o rises INTERVAL cycles after own_o falls.
- R13: A grant while req_o is low has no effect: no command is issued and own_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| grant_i | input | 1 | Sequencer hands over the command bus (accepted only while req_o is high) |
| sleep_req_i | input | 1 | Request to enter and remain in self-refresh |
| bank_open_i | input | NUM_BANKS | One bit per bank that currently has an open row |
| req_o | output | 1 | Bus request for refresh or self-refresh entry |
| urgent_o | output | 1 | Debt is at its ceiling; new row activations must stop |
| own_o | output | 1 | This block drives the command bus |
| cke_o | output | 1 | Memory clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| a10_o | output | 1 | Address bit 10; high selects all banks for precharge |

## Verification
Every output is decoded straight from registered state. A grant sampled at edge k therefore shows its first command after edge k+1. The refresh comes TRP_CYC edges after the precharge, each further refresh TRC_CYC edges after the one before it, and own_o falls TRC_CYC edges after the last refresh. Debt changes appear after the edge that ends the expiring interval, at multiples of INTERVAL edges. The driver pushes each expected command or clock-enable change into the queue with the edge count at which it is due. The monitor samples at falling edges and pops one entry for each observed event, so both early and late events fail. Level checks such as req_o, urgent_o and own_o are made one cycle before and at the computed edge.

// File: rtl/srpm_pkg.sv
package srpm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_WAIT_RP,
      ST_REF,
      ST_WAIT_RC,
      ST_SR_ENTER,
      ST_SR_HOLD,
      ST_SR_EXIT
   } srpm_state_e;

   // {cs_n, ras_n, cas_n, we_n}
   localparam logic [3:0] CMD_NOP = 4'b0111;
   localparam logic [3:0] CMD_PRE = 4'b0010;
   localparam logic [3:0] CMD_REF = 4'b0001;

   // Minimum time in ns converted to whole clocks, rounded up.
   function automatic int ns_to_cycles(input int ns, input int mhz);
      return (ns * mhz + 999) / 1000;
   endfunction

   // Average refresh slot in clocks, rounded down.
   function automatic int slot_cycles(input int window_ms, input int rows, input int mhz);
      return (window_ms * 1000 * mhz) / rows;
   endfunction

endpackage

// File: rtl/srpm_interval_tick.sv
module srpm_interval_tick #(
   parameter int INTERVAL = 1953
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_i,
   output logic tick_o
);
   localparam int CW = $clog2(INTERVAL);
   localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt_q <= '0;
      else if (hold_i)       cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
   end

   assign tick_o = !hold_i && (cnt_q == LAST);
endmodule

// File: rtl/srpm_debt_counter.sv
module srpm_debt_counter #(
   parameter int MAX_DEBT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc_i,
   input  logic dec_i,
   input  logic clr_i,
   output logic any_o,
   output logic full_o
);
   localparam int DW = $clog2(MAX_DEBT + 1);

   generate
      if (MAX_DEBT == 1) begin : g_flag
         logic owed_q;
         always_ff @(posedge clk) begin
            if (!rst_n)      owed_q <= 1'b0;
            else if (clr_i)  owed_q <= 1'b0;
            else if (inc_i)  owed_q <= 1'b1;
            else if (dec_i)  owed_q <= 1'b0;
         end
         assign any_o  = owed_q;
         assign full_o = owed_q;
      end else begin : g_count
         localparam logic [DW-1:0] TOP = DW'(MAX_DEBT);
         logic [DW-1:0] debt_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               debt_q <= '0;
            end else if (clr_i) begin
               debt_q <= '0;
            end else begin
               unique case ({inc_i, dec_i})
                  2'b10:   if (debt_q != TOP) debt_q <= debt_q + 1'b1;
                  2'b01:   if (debt_q != '0)  debt_q <= debt_q - 1'b1;
                  default: debt_q <= debt_q;
               endcase
            end
         end
         assign any_o  = (debt_q != '0);
         assign full_o = (debt_q == TOP);
      end
   endgenerate
endmodule

// File: rtl/srpm_gap_timer.sv
module srpm_gap_timer #(
   parameter int TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [TW-1:0] load_val_i,
   output logic          zero_o
);
   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load_i)       cnt_q <= load_val_i;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/srpm_refresh_manager.sv
module srpm_refresh_manager
   import srpm_pkg::*;
#(
   parameter int CLK_MHZ       = 125,
   parameter int REF_WINDOW_MS = 64,
   parameter int REF_ROWS      = 4096,
   parameter int TRC_NS        = 65,
   parameter int TRP_NS        = 20,
   parameter int MAX_DEBT      = 8,
   parameter int NUM_BANKS     = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 grant_i,
   input  logic                 sleep_req_i,
   input  logic [NUM_BANKS-1:0] bank_open_i,
   output logic                 req_o,
   output logic                 urgent_o,
   output logic                 own_o,
   output logic                 cke_o,
   output logic                 cs_n_o,
   output logic                 ras_n_o,
   output logic                 cas_n_o,
   output logic                 we_n_o,
   output logic                 a10_o
);
   localparam int INTERVAL = slot_cycles(REF_WINDOW_MS, REF_ROWS, CLK_MHZ);
   localparam int TRC_CYC  = ns_to_cycles(TRC_NS, CLK_MHZ);
   localparam int TRP_CYC  = ns_to_cycles(TRP_NS, CLK_MHZ);
   localparam int TMAX     = (TRC_CYC > TRP_CYC) ? TRC_CYC : TRP_CYC;
   localparam int TW       = $clog2(TMAX + 1);
   localparam logic [TW-1:0] RP_LOAD = TW'(TRP_CYC - 2);
   localparam logic [TW-1:0] RC_LOAD = TW'(TRC_CYC - 2);
   localparam logic [TW-1:0] XS_LOAD = TW'(TRC_CYC - 1);

   generate
      if (TRP_CYC < 2) begin : g_bad_trp
         $error("precharge gap must be at least two clocks");
      end
      if (TRC_CYC < 2) begin : g_bad_trc
         $error("row-cycle gap must be at least two clocks");
      end
      if (INTERVAL <= TRC_CYC * (MAX_DEBT + 2)) begin : g_bad_int
         $error("refresh slot too short for the debt ceiling");
      end
      if (MAX_DEBT < 1) begin : g_bad_debt
         $error("debt ceiling must be at least one");
      end
      if (NUM_BANKS < 1) begin : g_bad_banks
         $error("at least one bank required");
      end
   endgenerate

   srpm_state_e st_q, st_d;
   logic        to_sleep_q;
   logic        tick, debt_any, debt_full;
   logic        tmr_load, tmr_zero;
   logic [TW-1:0] tmr_val;
   logic        in_sr;
   logic [3:0]  cmd;

   assign in_sr = (st_q == ST_SR_ENTER) || (st_q == ST_SR_HOLD) || (st_q == ST_SR_EXIT);

   srpm_interval_tick #(.INTERVAL(INTERVAL)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold_i (in_sr),
      .tick_o (tick)
   );

   srpm_debt_counter #(.MAX_DEBT(MAX_DEBT)) u_debt (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc_i  (tick),
      .dec_i  (st_q == ST_REF),
      .clr_i  (st_q == ST_SR_ENTER),
      .any_o  (debt_any),
      .full_o (debt_full)
   );

   srpm_gap_timer #(.TW(TW)) u_gap (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .zero_o     (tmr_zero)
   );

   assign req_o = (st_q == ST_IDLE) && (debt_any || sleep_req_i);

   always_comb begin
      st_d     = st_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (st_q)
         ST_IDLE: begin
            if (grant_i && req_o) begin
               if (|bank_open_i)     st_d = ST_PRE;
               else if (sleep_req_i) st_d = ST_SR_ENTER;
               else                  st_d = ST_REF;
            end
         end
         ST_PRE: begin
            st_d     = ST_WAIT_RP;
            tmr_load = 1'b1;
            tmr_val  = RP_LOAD;
         end
         ST_WAIT_RP: begin
            if (tmr_zero) st_d = to_sleep_q ? ST_SR_ENTER : ST_REF;
         end
         ST_REF: begin
            st_d     = ST_WAIT_RC;
            tmr_load = 1'b1;
            tmr_val  = RC_LOAD;
         end
         ST_WAIT_RC: begin
            if (tmr_zero) st_d = debt_any ? ST_REF : ST_IDLE;
         end
         ST_SR_ENTER: st_d = ST_SR_HOLD;
         ST_SR_HOLD: begin
            if (!sleep_req_i) begin
               st_d     = ST_SR_EXIT;
               tmr_load = 1'b1;
               tmr_val  = XS_LOAD;
            end
         end
         ST_SR_EXIT: begin
            if (tmr_zero) st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         to_sleep_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_IDLE && grant_i && req_o) to_sleep_q <= sleep_req_i;
      end
   end

   always_comb begin
      unique case (st_q)
         ST_PRE:                cmd = CMD_PRE;
         ST_REF, ST_SR_ENTER:   cmd = CMD_REF;
         default:               cmd = CMD_NOP;
      endcase
   end

   assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd;
   assign a10_o    = (st_q == ST_PRE);
   assign cke_o    = !((st_q == ST_SR_ENTER) || (st_q == ST_SR_HOLD));
   assign own_o    = (st_q != ST_IDLE);
   assign urgent_o = debt_full;
endmodule

// File: rtl/srpm_checks.sv
module srpm_checks
   import srpm_pkg::*;
#(
   parameter int CLK_MHZ = 125,
   parameter int TRC_NS  = 65,
   parameter int TRP_NS  = 20
) (
   input logic clk,
   input logic rst_n,
   input logic req_o,
   input logic urgent_o,
   input logic own_o,
   input logic cke_o,
   input logic cs_n_o,
   input logic ras_n_o,
   input logic cas_n_o,
   input logic we_n_o
);
   localparam int TRC_CYC = ns_to_cycles(TRC_NS, CLK_MHZ);
   localparam int TRP_CYC = ns_to_cycles(TRP_NS, CLK_MHZ);

   logic [3:0]  cmd;
   logic [15:0] since_pre, since_ref;

   assign cmd = {cs_n_o, ras_n_o, cas_n_o, we_n_o};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_pre <= 16'hFFFF;
         since_ref <= 16'hFFFF;
      end else begin
         if (cmd == CMD_PRE)            since_pre <= 16'd1;
         else if (since_pre != 16'hFFFF) since_pre <= since_pre + 16'd1;
         if (cmd == CMD_REF)            since_ref <= 16'd1;
         else if (since_ref != 16'hFFFF) since_ref <= since_ref + 16'd1;
      end
   end

   AST_REQ_QUIET_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
      own_o |-> !req_o); // R2
   AST_PRE_TO_REF_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_REF) |-> (since_pre >= 16'(TRP_CYC))); // R3
   AST_RC_GAP_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != CMD_NOP) |-> (since_ref >= 16'(TRC_CYC))); // R5
   AST_RC_GAP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(own_o) |-> (since_ref >= 16'(TRC_CYC))); // R5
   AST_URGENT_REQUESTS: assert property (@(posedge clk) disable iff (!rst_n)
      (urgent_o && !own_o) |-> req_o); // R8
   AST_SR_ENTRY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cke_o) |-> (cmd == CMD_REF && own_o)); // R9
   AST_SR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_o && !$fell(cke_o)) |-> (cmd == CMD_NOP && !req_o && own_o)); // R10
   AST_CKE_LEADS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cke_o) |=> (cmd == CMD_NOP && own_o)); // R11
endmodule

bind srpm_refresh_manager srpm_checks #(
   .CLK_MHZ (CLK_MHZ),
   .TRC_NS  (TRC_NS),
   .TRP_NS  (TRP_NS)
) u_checks (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_o    (req_o),
   .urgent_o (urgent_o),
   .own_o    (own_o),
   .cke_o    (cke_o),
   .cs_n_o   (cs_n_o),
   .ras_n_o  (ras_n_o),
   .cas_n_o  (cas_n_o),
   .we_n_o   (we_n_o)
);

// File: tb/tb_srpm_refresh_manager.sv
`timescale 1ns/1ps
module tb_srpm_refresh_manager;
   localparam int T  = (64 * 1000 * 125) / 4096;   // 1953
   localparam int RP = (20 * 125 + 999) / 1000;    // 3
   localparam int RC = (65 * 125 + 999) / 1000;    // 9
   localparam logic [3:0] NOP = 4'b0111;
   localparam logic [3:0] PRE = 4'b0010;
   localparam logic [3:0] REF = 4'b0001;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic grant = 1'b0;
   logic sleep = 1'b0;
   logic [3:0] banks = 4'b0000;
   logic req, urgent, own, cke, cs_n, ras_n, cas_n, we_n, a10;

   int cyc = 0;
   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   srpm_refresh_manager dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .grant_i     (grant),
      .sleep_req_i (sleep),
      .bank_open_i (banks),
      .req_o       (req),
      .urgent_o    (urgent),
      .own_o       (own),
      .cke_o       (cke),
      .cs_n_o      (cs_n),
      .ras_n_o     (ras_n),
      .cas_n_o     (cas_n),
      .we_n_o      (we_n),
      .a10_o       (a10)
   );

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   typedef struct {
      int         at;
      logic [3:0] cmd;
      logic       a10;
      logic       cke;
      string      req;
   } ev_t;

   ev_t        exp_q[$];
   ev_t        mon_e;
   logic [3:0] mon_cmd;
   logic       mon_prev_cke = 1'b1;

   task automatic expect_ev(input int at, input logic [3:0] c, input logic a, input logic k,
                            input string r);
      ev_t e;
      e.at = at; e.cmd = c; e.a10 = a; e.cke = k; e.req = r;
      exp_q.push_back(e);
   endtask

   // Monitor: every command or clock-enable change must match the next expected item.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         mon_cmd = {cs_n, ras_n, cas_n, we_n};
         if (mon_cmd != NOP || cke != mon_prev_cke) begin
            n_chk++;
            if (exp_q.size() == 0) begin
               n_fail++;
               $display("FAIL R13 unexpected event at %0d: cmd=%b a10=%b cke=%b, expected none",
                        cyc, mon_cmd, a10, cke);
            end else begin
               mon_e = exp_q.pop_front();
               if (mon_e.at != cyc || mon_e.cmd != mon_cmd || mon_e.a10 != a10 || mon_e.cke != cke) begin
                  n_fail++;
                  $display("FAIL %s event: actual at=%0d cmd=%b a10=%b cke=%b, expected at=%0d cmd=%b a10=%b cke=%b",
                           mon_e.req, cyc, mon_cmd, a10, cke, mon_e.at, mon_e.cmd, mon_e.a10, mon_e.cke);
               end
            end
         end
         mon_prev_cke = cke;
      end
   end

   task automatic check(input string r, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", r, what, cyc, act, exp);
      end
   endtask

   task automatic wait_cyc(input int k);
      while (cyc < k) @(negedge clk);
   endtask

   task automatic grant_at(input int k, input logic [3:0] b);
      wait_cyc(k);
      banks = b;
      grant = 1'b1;
      @(negedge clk);
      grant = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(40000 * 8);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      finish_run();
   end

   initial begin
      int x;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "cke", cke, 1);
      check("R1", "cmd", {cs_n, ras_n, cas_n, we_n}, NOP);
      check("R1", "req/urgent/own/a10", {req, urgent, own, a10}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "own after release", own, 0);

      // R13 grant without request
      grant_at(100, 4'b1111);
      check("R13", "own after stray grant", own, 0);
      @(negedge clk);
      check("R13", "own one cycle later", own, 0);

      // R2 interval
      wait_cyc(T - 1);
      check("R2", "req before interval", req, 0);
      wait_cyc(T);
      check("R2", "req at interval", req, 1);
      check("R8", "urgent with one owed", urgent, 0);

      // R3 precharge then refresh, R5 release
      expect_ev(T + 6, PRE, 1'b1, 1'b1, "R3");
      expect_ev(T + 6 + RP, REF, 1'b0, 1'b1, "R3");
      grant_at(T + 5, 4'b0101);
      wait_cyc(T + 6 + RP + RC - 1);
      check("R5", "own before release", own, 1);
      wait_cyc(T + 6 + RP + RC);
      check("R5", "own at release", own, 0);
      check("R5", "req after payoff", req, 0);

      // R4 no precharge when banks closed
      expect_ev(2 * T + 6, REF, 1'b0, 1'b1, "R4");
      grant_at(2 * T + 5, 4'b0000);
      wait_cyc(2 * T + 6 + RC);
      check("R4", "own at release", own, 0);

      // R8 urgent, R7 saturation
      wait_cyc(10 * T - 1);
      check("R8", "urgent at seven owed", urgent, 0);
      wait_cyc(10 * T);
      check("R8", "urgent at ceiling", urgent, 1);
      wait_cyc(11 * T + 2);
      check("R7", "urgent after extra expiry", urgent, 1);

      // R6 back-to-back burst of exactly eight
      expect_ev(11 * T + 6, PRE, 1'b1, 1'b1, "R6");
      for (int i = 0; i < 8; i++)
         expect_ev(11 * T + 6 + RP + i * RC, REF, 1'b0, 1'b1, "R6");
      grant_at(11 * T + 5, 4'b1111);
      wait_cyc(11 * T + 6 + RP + 8 * RC - 1);
      check("R6", "own before burst end", own, 1);
      wait_cyc(11 * T + 6 + RP + 8 * RC);
      check("R7", "own after exactly eight", own, 0);
      check("R7", "req after burst", req, 0);
      check("R8", "urgent after burst", urgent, 0);

      // R9 sleep entry with debt outstanding
      wait_cyc(12 * T + 1);
      check("R2", "req with one owed", req, 1);
      wait_cyc(12 * T + 20);
      sleep = 1'b1;
      expect_ev(12 * T + 22, PRE, 1'b1, 1'b1, "R9");
      expect_ev(12 * T + 22 + RP, REF, 1'b0, 1'b0, "R9");
      grant_at(12 * T + 21, 4'b1000);
      wait_cyc(12 * T + 26);
      check("R9", "cke in self-refresh", cke, 0);
      check("R9", "own in self-refresh", own, 1);

      // R10 quiet while asleep
      wait_cyc(15 * T);
      check("R10", "cke held low", cke, 0);
      check("R10", "req while asleep", req, 0);

      // R11 exit
      x = 15 * T + 10;
      wait_cyc(x);
      expect_ev(x + 1, NOP, 1'b0, 1'b1, "R11");
      sleep = 1'b0;
      wait_cyc(x + RC);
      check("R11", "own during exit", own, 1);
      wait_cyc(x + RC + 1);
      check("R11", "own after exit", own, 0);
      check("R9", "debt cleared by entry", req, 0);

      // R12 interval restarts
      wait_cyc(x + RC + 1 + T - 1);
      check("R12", "req before restarted interval", req, 0);
      wait_cyc(x + RC + 1 + T);
      check("R12", "req at restarted interval", req, 1);

      repeat (4) @(negedge clk);
      check("R6", "expected events left", exp_q.size(), 0);
      finish_run();
   end
endmodule